// File: doc/BRIEF.md
# Dual Half Timer

A memory-mapped general purpose timer made from two 16-bit halves, A and B, that share one register set. A configuration value chosen before the timer is started decides how the halves work. They can act as one 32-bit down-counter, as one 32-bit real-time counter advanced by a 1 Hz tick, or as two separate 16-bit down-counters. Software programs the registers over a simple single-cycle write bus. Reads return data combinationally for the address presented.

A timeout or an RTC match sets a bit in the raw status register. The level interrupt output is high while any raw status bit that is also enabled in the mask register is set. When its control bit is set, a countdown timeout of the joined 32-bit timer also drives a one-cycle pulse on a trigger output, which can start a converter. Configuration and mode values are sampled only when a timer is enabled, so software can reprogram them while the timer runs without disturbing the current run. The prescale registers only hold values and do not affect counting. The 1 Hz tick comes from an internal divider set by the `TICK_DIV` parameter.

Top module: `dual_half_timer`

## Requirements
- R1: When configuration (0x00, bits 2:0) is 0, enabling timer A loads {load B, load A} and counts down by one each cycle. The cycle after the count reaches zero is a timeout, so the timeout comes reload+1 cycles after the enabling write. The timeout sets raw status bit 0.
- R2: Mode A register (0x04) bit 0 is sampled at enable. When it is set, timer A stops after its first timeout. When it is clear, timer A reloads on each timeout and keeps running, with one timeout every reload+1 cycles.
- R3: A countdown timeout in configuration 0 drives `adc_trig` high for exactly one cycle, one cycle after the timeout edge, if control bit 5 was set. Otherwise `adc_trig` stays low.
- R4: When configuration is 1, enabling timer A clears the count and the tick divider. The count then increments once every `TICK_DIV` cycles. When the incremented count equals {match B, match A}, raw status bit 2 is set. The count reads back at 0x48.
- R5: A 0-to-1 write of control (0x0C) bit 0 starts timer A, and a 1-to-0 write stops it. Configuration changes written after the start do not affect a timer that is already running.
- R6: When the configuration is 4 or above, a 0-to-1 write of control bit 8 starts timer B and a 1-to-0 write stops it. Timer B is a 16-bit down-counter from load B and sets raw status bit 4 on timeout. Mode B bit 0 selects one-shot. Timer A counts down from load A alone in this mode. When the configuration is below 4, control bit 8 has no effect.
- R7: The mask register (0x18) stores only bits 0x77. `irq` is high while (raw status AND mask) is nonzero, and 0x20 reads back that AND.
- R8: Writing a 1 to a bit at 0x24 clears that raw status bit. If a new event sets the same bit in the same cycle, the set wins. Raw status reads at 0x1C.
- R9: A write to 0x28 stores bits 15:0 in load A, and also stores bits 31:16 in load B when the configuration is below 4. A read of 0x28 returns {load B, load A} under the same condition, and {16'b0, load A} otherwise. 0x2C reads and writes load B alone. 0x30 and 0x34 do the same for the match values.
- R10: After reset all registers, `irq` and `adc_trig` are zero. The registers at 0x38, 0x3C, 0x40 and 0x44 store and return 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt |
| adc_trig | output | 1 | One-cycle converter trigger pulse |

## Verification
On every cycle, the embedded properties check the following:
- a trigger pulse never appears without the timeout flag;
- the interrupt never rises with an empty mask;
- timer A halts only on a stop write or after a one-shot timeout;
- the RTC count never jumps by more than one;
- a timeout flag is never lost to a simultaneous clear;
- timer B starts only in split configurations.

Other behaviours need the bench's scenarios to show them:
- the exact cycle of each timeout;
- periodic reload;
- the RTC match instant;
- configuration being sampled at enable;
- the joined register widths.

// File: rtl/dual_half_timer.sv
module dual_half_timer #(
  parameter int TICK_DIV = 50_000_000,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              adc_trig
);
  localparam int HW    = 16;
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
  localparam logic [6:0] MASK_KEEP = 7'h77;

  localparam logic [ADDR_W-1:0] A_CFG = 'h00, A_MODEA = 'h04, A_MODEB = 'h08,
    A_CTRL = 'h0C, A_MASK = 'h18, A_RAW = 'h1C, A_MSK = 'h20, A_CLR = 'h24,
    A_LOAD = 'h28, A_LOADB = 'h2C, A_MATCH = 'h30, A_MATCHB = 'h34,
    A_PREA = 'h38, A_PREB = 'h3C, A_PMA = 'h40, A_PMB = 'h44, A_CNT = 'h48;

  logic [2:0]    cfg_q;
  logic [3:0]    mode_a_q, mode_b_q;
  logic [15:0]   ctrl_q;
  logic [6:0]    mask_q, raw_q;
  logic [HW-1:0] load_a, load_b, match_a, match_b, pre_a, pre_b, pmat_a, pmat_b;

  logic          run_a, a_oneshot, run_b, b_oneshot, trig_q;
  logic [2:0]    a_cfg;
  logic [31:0]   cnt_a;
  logic [HW-1:0] cnt_b;
  logic [DIV_W-1:0] div_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a);
    return bus_wr && (bus_addr == a);
  endfunction

  wire joined  = (cfg_q < 3'd4);
  wire ctrl_w  = hit(A_CTRL);
  wire a_on    = ctrl_w &&  bus_wdata[0] && !ctrl_q[0];
  wire a_off   = ctrl_w && !bus_wdata[0] &&  ctrl_q[0];
  wire b_on    = ctrl_w && !joined &&  bus_wdata[8] && !ctrl_q[8];
  wire b_off   = ctrl_w && !joined && !bus_wdata[8] &&  ctrl_q[8];

  wire a_down  = run_a && (a_cfg == 3'd0 || a_cfg >= 3'd4);
  wire a_rtc   = run_a && (a_cfg == 3'd1);
  wire [31:0] a_reload = (a_cfg == 3'd0) ? {load_b, load_a} : {16'h0, load_a};
  wire a_ev    = a_down && (cnt_a == 32'h0) && !a_on && !a_off;
  wire tick    = a_rtc && (div_q == DIV_LAST) && !a_on && !a_off;
  wire [31:0] rtc_next = cnt_a + 32'd1;
  wire rtc_hit = tick && (rtc_next == {match_b, match_a});
  wire b_ev    = run_b && (cnt_b == '0) && !b_on && !b_off;

  wire [6:0] set_bits = {2'b00, b_ev, 1'b0, rtc_hit, 1'b0, a_ev};
  wire [6:0] clr_bits = hit(A_CLR) ? bus_wdata[6:0] : 7'h0;

  assign irq      = |(raw_q & mask_q);
  assign adc_trig = trig_q;

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; mode_a_q <= '0; mode_b_q <= '0; ctrl_q <= '0;
      mask_q <= '0; raw_q <= '0;
      load_a <= '0; load_b <= '0; match_a <= '0; match_b <= '0;
      pre_a <= '0; pre_b <= '0; pmat_a <= '0; pmat_b <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_bits) | set_bits;
      if (hit(A_CFG))   cfg_q    <= bus_wdata[2:0];
      if (hit(A_MODEA)) mode_a_q <= bus_wdata[3:0];
      if (hit(A_MODEB)) mode_b_q <= bus_wdata[3:0];
      if (ctrl_w)       ctrl_q   <= bus_wdata[15:0];
      if (hit(A_MASK))  mask_q   <= bus_wdata[6:0] & MASK_KEEP;
      if (hit(A_LOAD)) begin
        load_a <= bus_wdata[15:0];
        if (joined) load_b <= bus_wdata[31:16];
      end
      if (hit(A_LOADB)) load_b <= bus_wdata[15:0];
      if (hit(A_MATCH)) begin
        match_a <= bus_wdata[15:0];
        if (joined) match_b <= bus_wdata[31:16];
      end
      if (hit(A_MATCHB)) match_b <= bus_wdata[15:0];
      if (hit(A_PREA))   pre_a   <= bus_wdata[15:0];
      if (hit(A_PREB))   pre_b   <= bus_wdata[15:0];
      if (hit(A_PMA))    pmat_a  <= bus_wdata[15:0];
      if (hit(A_PMB))    pmat_b  <= bus_wdata[15:0];
    end
  end

  // timer A: 32-bit countdown, RTC, or 16-bit split countdown
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_a <= 1'b0; a_cfg <= '0; a_oneshot <= 1'b0; cnt_a <= '0; div_q <= '0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= a_ev && (a_cfg == 3'd0) && ctrl_q[5];
      if (a_on) begin
        run_a     <= 1'b1;
        a_cfg     <= cfg_q;
        a_oneshot <= mode_a_q[0];
        div_q     <= '0;
        cnt_a     <= (cfg_q == 3'd1) ? 32'h0 :
                     (cfg_q == 3'd0) ? {load_b, load_a} : {16'h0, load_a};
      end else if (a_off) begin
        run_a <= 1'b0;
      end else if (a_ev) begin
        if (a_oneshot) run_a <= 1'b0;
        else           cnt_a <= a_reload;
      end else if (a_down) begin
        cnt_a <= cnt_a - 32'd1;
      end else if (a_rtc) begin
        if (tick) begin
          div_q <= '0;
          cnt_a <= rtc_next;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  // timer B: 16-bit countdown in split configurations
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_b <= 1'b0; b_oneshot <= 1'b0; cnt_b <= '0;
    end else if (b_on) begin
      run_b <= 1'b1; b_oneshot <= mode_b_q[0]; cnt_b <= load_b;
    end else if (b_off) begin
      run_b <= 1'b0;
    end else if (b_ev) begin
      if (b_oneshot) run_b <= 1'b0;
      else           cnt_b <= load_b;
    end else if (run_b) begin
      cnt_b <= cnt_b - 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CFG:    bus_rdata = {29'h0, cfg_q};
      A_MODEA:  bus_rdata = {28'h0, mode_a_q};
      A_MODEB:  bus_rdata = {28'h0, mode_b_q};
      A_CTRL:   bus_rdata = {16'h0, ctrl_q};
      A_MASK:   bus_rdata = {25'h0, mask_q};
      A_RAW:    bus_rdata = {25'h0, raw_q};
      A_MSK:    bus_rdata = {25'h0, raw_q & mask_q};
      A_LOAD:   bus_rdata = {joined ? load_b : 16'h0, load_a};
      A_LOADB:  bus_rdata = {16'h0, load_b};
      A_MATCH:  bus_rdata = {joined ? match_b : 16'h0, match_a};
      A_MATCHB: bus_rdata = {16'h0, match_b};
      A_PREA:   bus_rdata = {16'h0, pre_a};
      A_PREB:   bus_rdata = {16'h0, pre_b};
      A_PMA:    bus_rdata = {16'h0, pmat_a};
      A_PMB:    bus_rdata = {16'h0, pmat_b};
      A_CNT:    bus_rdata = cnt_a;
      default:  bus_rdata = '0;
    endcase
  end

  a_r3_trig_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> raw_q[0]);
  a_r7_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != 7'h0));
  a_r2_halt_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_a) |-> ($past(a_oneshot) || !ctrl_q[0]));
  a_r4_rtc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rtc && $past(a_rtc) && !$past(a_on)) |->
      (cnt_a == $past(cnt_a) || cnt_a == $past(cnt_a) + 32'd1));
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(a_ev) |-> raw_q[0]);
  a_r6_b_split_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_b) |-> ($past(cfg_q) >= 3'd4));
endmodule

// File: tb/dual_half_timer_tb_top.sv
module dual_half_timer_tb_top;
  localparam int TICK_DIV = 4;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, adc_trig;
  int nvec = 0, nbad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_half_timer #(.TICK_DIV(TICK_DIV), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .adc_trig(adc_trig));

  // {is_write, addr, data, expected}; tags R7 R9 R10
  localparam int NV = 18;
  localparam logic [72:0] VEC [0:NV-1] = '{
    {1'b0, 8'h00, 32'h0,        32'h0},
    {1'b0, 8'h1C, 32'h0,        32'h0},
    {1'b0, 8'h28, 32'h0,        32'h0},
    {1'b0, 8'h0C, 32'h0,        32'h0},
    {1'b1, 8'h18, 32'hFFFFFFFF, 32'h0},
    {1'b0, 8'h18, 32'h0,        32'h77},
    {1'b1, 8'h28, 32'h12345678, 32'h0},
    {1'b0, 8'h28, 32'h0,        32'h12345678},
    {1'b0, 8'h2C, 32'h0,        32'h1234},
    {1'b1, 8'h30, 32'hCAFE0001, 32'h0},
    {1'b0, 8'h30, 32'h0,        32'hCAFE0001},
    {1'b0, 8'h34, 32'h0,        32'hCAFE},
    {1'b1, 8'h38, 32'h000000AB, 32'h0},
    {1'b0, 8'h38, 32'h0,        32'hAB},
    {1'b1, 8'h44, 32'h00005A5A, 32'h0},
    {1'b0, 8'h44, 32'h0,        32'h5A5A},
    {1'b1, 8'h18, 32'h0,        32'h0},
    {1'b0, 8'h20, 32'h0,        32'h0}
  };

  function automatic string vtag(input int i);
    case (i)
      0, 1, 2, 3, 13, 15: return "R10";
      5, 17:              return "R7";
      default:            return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1 chk(req, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", {30'h0, irq, adc_trig}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      else            rd(vtag(i), VEC[i][71:64], VEC[i][31:0]);
    end

    // R1 R3 R2: one-shot 32-bit countdown with trigger
    wr(8'h00, 0); wr(8'h04, 1); wr(8'h28, 5); wr(8'h18, 1); wr(8'h0C, 32'h21);
    idle(5); chk("R1", {31'h0, irq}, 0);
    idle(1); chk("R1", {31'h0, irq}, 1); chk("R3", {31'h0, adc_trig}, 1);
    idle(1); chk("R3", {31'h0, adc_trig}, 0);
    idle(20); rd("R1", 8'h1C, 1);
    wr(8'h24, 1); idle(20); rd("R2", 8'h1C, 0); rd("R2", 8'h48, 0);

    // R2 R5 R8: periodic, no trigger, config sampled at enable
    wr(8'h0C, 0); wr(8'h04, 0); wr(8'h0C, 1);
    idle(6); rd("R2", 8'h1C, 1); chk("R3", {31'h0, adc_trig}, 0);
    wr(8'h24, 1); rd("R8", 8'h1C, 0);
    idle(5); rd("R2", 8'h1C, 1);
    wr(8'h00, 3); wr(8'h24, 1);
    idle(4); rd("R5", 8'h1C, 1);
    idle(5); wr(8'h24, 1); rd("R8", 8'h1C, 1);
    wr(8'h0C, 0); wr(8'h24, 32'h7F); idle(10); rd("R5", 8'h1C, 0);

    // R4 R7: RTC count and match
    wr(8'h00, 1); wr(8'h30, 3); wr(8'h18, 4); wr(8'h0C, 1);
    idle(11); chk("R4", {31'h0, irq}, 0); rd("R4", 8'h48, 2);
    idle(1);  chk("R4", {31'h0, irq}, 1); rd("R4", 8'h48, 3); rd("R7", 8'h20, 4);
    wr(8'h0C, 0);

    // R6 R9: split halves, timer B
    wr(8'h24, 32'h7F); wr(8'h00, 4); wr(8'h28, 32'h00070003);
    rd("R9", 8'h28, 3);
    wr(8'h2C, 2); rd("R9", 8'h2C, 2);
    wr(8'h18, 32'h10); wr(8'h0C, 32'h100);
    idle(2); chk("R6", {31'h0, irq}, 0);
    idle(1); chk("R6", {31'h0, irq}, 1);
    wr(8'h0C, 0); wr(8'h00, 0); rd("R9", 8'h28, 32'h00020003);
    wr(8'h24, 32'h7F); wr(8'h0C, 32'h100);
    idle(10); rd("R6", 8'h1C, 0); chk("R6", {31'h0, irq}, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule